// File: doc/BRIEF.md
# Byte-Serial Register Access Bridge

This block turns single 32-bit register reads and writes from a local host into transfers over a narrow management port. The port carries an 8-bit data path in each direction, a 12-bit byte address, one strobe for reads, one strobe for writes, and an acknowledge from the target. A word crosses the port as four byte beats on back-to-back clock cycles, lowest byte first.

The host presents a request with a direction select, an address and write data. It then waits while `host_busy` is high. A one-cycle `host_done` pulse marks success, and on a read the assembled word is on `host_rdata`. Two other one-cycle pulses report failure. `host_err_align` means the address was not word aligned, so nothing was sent on the port. `host_err_tmo` means the target never acknowledged, so the access was abandoned.

Top module: `byte_serial_bridge`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `host_busy`, `host_done`, both error pulses, `mp_wr` and `mp_rd` are low and `host_rdata` is zero.
- R2: An aligned write raises `mp_wr` for four beats in a row. During those beats `mp_addr` equals host address bits 11:0 and `mp_wdata` carries host data bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R3: After the fourth write beat, `mp_wr` stays high until a clock edge samples `mp_ack` high. In the next cycle `host_done` is high, `host_busy` is low and both strobes are low.
- R4: An aligned read holds `mp_rd` high with the address until an edge samples `mp_ack` high. `mp_rdata` at that edge and at the next three edges fills bits 7:0, 15:8, 23:16 and 31:24. `host_done` pulses in the cycle after the fourth capture, with the full word on `host_rdata`.
- R5: `mp_rd` and `mp_wr` are never high together, and neither is high while `host_busy` is low.
- R6: A request whose address bits 1:0 are not `00` gives a one-cycle `host_err_align` in the next cycle. It raises no strobe, and `host_busy` stays low.
- R7: A wait for acknowledge lasts at most 64 cycles. If no acknowledge arrives, the strobe drops, `host_err_tmo` pulses for one cycle and `host_busy` falls, with no `host_done`. An acknowledge in the 64th waiting cycle still completes the access.
- R8: `host_req` is ignored while `host_busy` is high: the port address and the outcome of the running access are unchanged.
- R9: `mp_ack` has no effect outside a wait for acknowledge.
- R10: `host_done` is a single-cycle pulse. `host_rdata` changes only when a read completes, so writes, errors and timeouts leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_req | input | 1 | Access request, sampled while idle |
| host_we | input | 1 | 1 selects a write, 0 selects a read |
| host_addr | input | 32 | Byte address; bits 11:0 reach the port |
| host_wdata | input | 32 | Write word |
| host_busy | output | 1 | An access is in progress |
| host_done | output | 1 | One-cycle pulse when an access completes |
| host_rdata | output | 32 | Last word read |
| host_err_align | output | 1 | One-cycle pulse when a misaligned request is rejected |
| host_err_tmo | output | 1 | One-cycle pulse when an access is abandoned for lack of acknowledge |
| mp_addr | output | 12 | Port byte address |
| mp_wdata | output | 8 | Port write byte |
| mp_wr | output | 1 | Port write strobe |
| mp_rd | output | 1 | Port read strobe |
| mp_rdata | input | 8 | Port read byte |
| mp_ack | input | 1 | Port acknowledge |

## Verification
The assertions assume three things about the inputs. The host holds its address and data steady in the cycle it raises `host_req`. The target raises `mp_ack` only while a strobe is high and the bridge is waiting. The target presents the remaining read bytes on the three cycles right after the acknowledge. The bench target model meets all three: it counts strobe cycles on falling edges and acknowledges only inside the wait window, at a programmed delay. The one exception is a deliberate idle acknowledge, which tests that such a pulse is ignored.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

  // Sequencer states of the bridge.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WBEAT = 3'd1,
    ST_WWAIT = 3'd2,
    ST_RWAIT = 3'd3,
    ST_RBEAT = 3'd4
  } bsb_state_e;

endpackage

// File: rtl/bsb_rst_sync.sv
// Asserts reset asynchronously and releases it after STAGES clock edges.
module bsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/bsb_wait_timer.sv
// Counts the cycles spent waiting for acknowledge; flags the last allowed one.
module bsb_wait_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = en && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/bsb_rd_assembler.sv
// Read word register: one byte lane per beat, each with its own enable.
module bsb_rd_assembler #(
  parameter int HDW = 32,
  parameter int PDW = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cap_en,
  input  logic [$clog2(HDW/PDW)-1:0]      lane_sel,
  input  logic [PDW-1:0]                  din,
  output logic [HDW-1:0]                  dout
);

  localparam int NLANE = HDW / PDW;
  localparam int LW    = $clog2(NLANE);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic lane_en;
    assign lane_en = cap_en && (lane_sel == LW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout[g*PDW +: PDW] <= '0;
      end else if (lane_en) begin
        dout[g*PDW +: PDW] <= din;
      end
    end
  end

endmodule

// File: rtl/byte_serial_bridge.sv
module byte_serial_bridge
  import bsb_pkg::*;
#(
  parameter int HAW     = 32,
  parameter int HDW     = 32,
  parameter int PAW     = 12,
  parameter int PDW     = 8,
  parameter int ACK_TMO = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [HDW-1:0] host_wdata,
  output logic           host_busy,
  output logic           host_done,
  output logic [HDW-1:0] host_rdata,
  output logic           host_err_align,
  output logic           host_err_tmo,
  output logic [PAW-1:0] mp_addr,
  output logic [PDW-1:0] mp_wdata,
  output logic           mp_wr,
  output logic           mp_rd,
  input  logic [PDW-1:0] mp_rdata,
  input  logic           mp_ack
);

  localparam int NBEATS  = HDW / PDW;
  localparam int BEAT_W  = $clog2(NBEATS);
  localparam int ALIGN_W = BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NBEATS - 1);

  logic rst_sync_n;

  bsb_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  bsb_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [PAW-1:0]    addr_q;
  logic [HDW-1:0]    wdata_q;
  logic              done_q, done_d;
  logic              ealign_q, ealign_d;
  logic              etmo_q, etmo_d;
  logic              accept;
  logic              cap_en;
  logic              waiting;
  logic              tmo_hit;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^host_addr[HAW-1:PAW];
  assign waiting = (state_q == ST_WWAIT) || (state_q == ST_RWAIT);

  bsb_wait_timer #(.LIMIT(ACK_TMO)) wait_timer_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (!waiting),
    .en      (waiting),
    .expired (tmo_hit)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    done_d   = 1'b0;
    ealign_d = 1'b0;
    etmo_d   = 1'b0;
    accept   = 1'b0;
    cap_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          if (|host_addr[ALIGN_W-1:0]) begin
            ealign_d = 1'b1;
          end else begin
            accept  = 1'b1;
            beat_d  = '0;
            state_d = host_we ? ST_WBEAT : ST_RWAIT;
          end
        end
      end
      ST_WBEAT: begin
        if (beat_q == LAST_BEAT) begin
          state_d = ST_WWAIT;
        end else begin
          beat_d = beat_q + BEAT_W'(1);
        end
      end
      ST_WWAIT: begin
        if (mp_ack) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmo_hit) begin
          etmo_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RWAIT: begin
        if (mp_ack) begin
          cap_en  = 1'b1;
          beat_d  = BEAT_W'(1);
          state_d = ST_RBEAT;
        end else if (tmo_hit) begin
          etmo_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RBEAT: begin
        cap_en = 1'b1;
        if (beat_q == LAST_BEAT) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          beat_d = beat_q + BEAT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      done_q   <= 1'b0;
      ealign_q <= 1'b0;
      etmo_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      done_q   <= done_d;
      ealign_q <= ealign_d;
      etmo_q   <= etmo_d;
    end
  end

  // Request capture, enabled on accept only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= host_addr[PAW-1:0];
      wdata_q <= host_wdata;
    end
  end

  bsb_rd_assembler #(.HDW(HDW), .PDW(PDW)) rd_asm_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_en   (cap_en),
    .lane_sel (beat_q),
    .din      (mp_rdata),
    .dout     (host_rdata)
  );

  assign mp_wr          = (state_q == ST_WBEAT) || (state_q == ST_WWAIT);
  assign mp_rd          = (state_q == ST_RWAIT);
  assign mp_addr        = addr_q;
  assign mp_wdata       = wdata_q[beat_q*PDW +: PDW];
  assign host_busy      = (state_q != ST_IDLE);
  assign host_done      = done_q;
  assign host_err_align = ealign_q;
  assign host_err_tmo   = etmo_q;

endmodule

// File: rtl/bsb_checker.sv
module bsb_checker #(
  parameter int ALIGN_W = 2,
  parameter int PDW     = 8,
  parameter int PAW     = 12,
  parameter int ACK_TMO = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_busy,
  input logic               host_done,
  input logic               host_err_align,
  input logic               host_err_tmo,
  input logic [ALIGN_W-1:0] host_addr_lo,
  input logic [PDW-1:0]     host_wdata_lo,
  input logic [PAW-1:0]     mp_addr,
  input logic [PDW-1:0]     mp_wdata,
  input logic               mp_wr,
  input logic               mp_rd,
  input logic               mp_ack
);

  logic [15:0] rd_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run_q <= '0;
    end else begin
      rd_run_q <= mp_rd ? rd_run_q + 16'd1 : 16'd0;
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mp_rd && mp_wr));

  assert_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_rd || mp_wr) |-> host_busy);

  assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mp_wr) |-> (mp_wdata == $past(host_wdata_lo)));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mp_rd || mp_wr) && $past(mp_rd || mp_wr)) |-> $stable(mp_addr));

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> (!host_busy && !mp_wr && !mp_rd));

  assert_misalign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_busy && (host_addr_lo != '0)) |=>
      (host_err_align && !mp_wr && !mp_rd && !host_busy));

  assert_rd_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mp_rd) |-> ($past(mp_ack) || host_err_tmo));

  assert_rd_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_run_q <= 16'(ACK_TMO));

  assert_tmo_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_err_tmo |-> (!mp_wr && !mp_rd && !host_busy && !host_done));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

endmodule

bind byte_serial_bridge bsb_checker #(
  .ALIGN_W (ALIGN_W),
  .PDW     (PDW),
  .PAW     (PAW),
  .ACK_TMO (ACK_TMO)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .host_req       (host_req),
  .host_busy      (host_busy),
  .host_done      (host_done),
  .host_err_align (host_err_align),
  .host_err_tmo   (host_err_tmo),
  .host_addr_lo   (host_addr[ALIGN_W-1:0]),
  .host_wdata_lo  (host_wdata[PDW-1:0]),
  .mp_addr        (mp_addr),
  .mp_wdata       (mp_wdata),
  .mp_wr          (mp_wr),
  .mp_rd          (mp_rd),
  .mp_ack         (mp_ack)
);

// File: tb/byte_serial_bridge_tb_top.sv
module byte_serial_bridge_tb_top;

  localparam int K_DONE_W = 0;
  localparam int K_DONE_R = 1;
  localparam int K_ALIGN  = 2;
  localparam int K_TMO    = 3;

  typedef struct {
    int          kind;
    logic [31:0] data;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req;
  logic        host_we;
  logic [31:0] host_addr;
  logic [31:0] host_wdata;
  logic        host_busy;
  logic        host_done;
  logic [31:0] host_rdata;
  logic        host_err_align;
  logic        host_err_tmo;
  logic [11:0] mp_addr;
  logic [7:0]  mp_wdata;
  logic        mp_wr;
  logic        mp_rd;
  logic [7:0]  mp_rdata;
  logic        mp_ack;

  logic        ack_r = 1'b0;
  logic        force_ack = 1'b0;
  logic [7:0]  rd_r = 8'h00;

  int          n_checks = 0;
  int          n_fails  = 0;
  int          pushed   = 0;
  int          seen     = 0;
  int          stb_cycles = 0;
  int          ovl_cnt  = 0;
  int          t_dly    = 0;
  logic [31:0] t_addr   = '0;
  logic [31:0] t_wdata  = '0;
  logic [31:0] last_rd  = '0;
  exp_t        sb_q[$];
  logic [31:0] exp_mem[int];
  logic [31:0] tgt_mem[int];

  always #2.5 clk = ~clk;

  assign mp_ack   = ack_r | force_ack;
  assign mp_rdata = rd_r;

  byte_serial_bridge dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_req       (host_req),
    .host_we        (host_we),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .host_busy      (host_busy),
    .host_done      (host_done),
    .host_rdata     (host_rdata),
    .host_err_align (host_err_align),
    .host_err_tmo   (host_err_tmo),
    .mp_addr        (mp_addr),
    .mp_wdata       (mp_wdata),
    .mp_wr          (mp_wr),
    .mp_rd          (mp_rd),
    .mp_rdata       (mp_rdata),
    .mp_ack         (mp_ack)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_get(ref logic [31:0] m[int], input int idx);
    return m.exists(idx) ? m[idx] : 32'h0;
  endfunction

  // Target model: counts strobe cycles on falling edges, checks beats, acknowledges.
  initial begin
    int          wn = 0;
    int          rn = 0;
    int          rb = 0;
    int          ridx = 0;
    logic [31:0] rword = '0;
    logic [31:0] wcol = '0;
    forever begin
      @(negedge clk);
      ack_r = 1'b0;
      if ((mp_wr && mp_rd) || ((mp_wr || mp_rd) && !host_busy)) ovl_cnt++;
      if (mp_wr || mp_rd) stb_cycles++;
      if (rb > 0) begin
        rd_r = rword[ridx*8 +: 8];
        ridx++;
        rb--;
      end
      if (mp_wr) begin
        wn++;
        if (wn <= 4) begin
          // R2: beat (wn-1) carries byte lane (wn-1), address is the low 12 bits
          check(mp_wdata == t_wdata[(wn-1)*8 +: 8], "R2 write beat byte",
                {24'h0, mp_wdata}, {24'h0, t_wdata[(wn-1)*8 +: 8]});
          wcol[(wn-1)*8 +: 8] = mp_wdata;
          if (wn == 4) tgt_mem[int'(mp_addr[11:2])] = wcol;
        end
        check(mp_addr == t_addr[11:0], "R8 write address held",
              {20'h0, mp_addr}, {20'h0, t_addr[11:0]});
        if (wn == 5 + t_dly) ack_r = 1'b1;
      end else begin
        wn = 0;
      end
      if (mp_rd) begin
        rn++;
        check(mp_addr == t_addr[11:0], "R8 read address held",
              {20'h0, mp_addr}, {20'h0, t_addr[11:0]});
        if (rn == 1 + t_dly) begin
          ack_r = 1'b1;
          rword = mem_get(tgt_mem, int'(mp_addr[11:2]));
          rd_r  = rword[7:0];
          rb    = 3;
          ridx  = 1;
        end
      end else begin
        rn = 0;
      end
    end
  end

  // Monitor: pops the scoreboard on every completion or error pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (host_done || host_err_align || host_err_tmo)) begin
        seen++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R8/R9 unexpected completion", {29'h0, host_done, host_err_align, host_err_tmo}, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(!host_busy && !mp_wr && !mp_rd, {e.req, " idle at result"},
                {29'h0, host_busy, mp_wr, mp_rd}, 32'h0);
          case (e.kind)
            K_DONE_W: begin
              check(host_done && !host_err_align && !host_err_tmo, {e.req, " write done"},
                    {29'h0, host_done, host_err_align, host_err_tmo}, 32'h4);
              check(host_rdata == last_rd, "R10 rdata kept over write", host_rdata, last_rd);
            end
            K_DONE_R: begin
              check(host_done && !host_err_align && !host_err_tmo, {e.req, " read done"},
                    {29'h0, host_done, host_err_align, host_err_tmo}, 32'h4);
              check(host_rdata == e.data, {e.req, " read word"}, host_rdata, e.data);
              last_rd = e.data;
            end
            K_ALIGN: begin
              check(host_err_align && !host_done && !host_err_tmo, {e.req, " align error"},
                    {29'h0, host_done, host_err_align, host_err_tmo}, 32'h2);
              check(host_rdata == last_rd, "R10 rdata kept over error", host_rdata, last_rd);
            end
            default: begin
              check(host_err_tmo && !host_done && !host_err_align, {e.req, " timeout"},
                    {29'h0, host_done, host_err_align, host_err_tmo}, 32'h1);
              check(host_rdata == last_rd, "R10 rdata kept over timeout", host_rdata, last_rd);
            end
          endcase
        end
        // R10: done must be gone in the following cycle
        @(negedge clk);
        check(!host_done, "R10 done single cycle", {31'h0, host_done}, 32'h0);
      end
    end
  end

  task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d,
                    input int dly, input int kind, input string req, input bit intrude);
    exp_t e;
    int   guard;
    @(negedge clk);
    t_dly   = dly;
    t_addr  = a;
    t_wdata = d;
    host_req   = 1'b1;
    host_we    = we;
    host_addr  = a;
    host_wdata = d;
    e.kind = kind;
    e.req  = req;
    e.data = (kind == K_DONE_R) ? mem_get(exp_mem, int'(a[11:2])) : 32'h0;
    if (kind == K_DONE_W) exp_mem[int'(a[11:2])] = d;
    sb_q.push_back(e);
    pushed++;
    @(negedge clk);
    host_req = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      host_req   = 1'b1;
      host_we    = 1'b0;
      host_addr  = 32'h0000_0301;
      host_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      host_req = 1'b0;
    end
    guard = 0;
    while (seen != pushed && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check(seen == pushed, {req, " result seen"}, 32'(seen), 32'(pushed));
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int s0;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!host_busy && !host_done && !host_err_align && !host_err_tmo && !mp_wr && !mp_rd,
          "R1 outputs in reset", {26'h0, host_busy, host_done, host_err_align, host_err_tmo, mp_wr, mp_rd}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!host_busy && !mp_wr && !mp_rd && host_rdata == 32'h0, "R1 state after release",
          host_rdata, 32'h0);

    // R2 R3 R4: basic write then read back
    op(1'b1, 32'h0000_0100, 32'hA1B2_C3D4, 0, K_DONE_W, "R3", 1'b0);
    op(1'b0, 32'h0000_0100, 32'h0, 0, K_DONE_R, "R4", 1'b0);
    op(1'b1, 32'h0000_0004, 32'h1122_3344, 5, K_DONE_W, "R3 delayed ack", 1'b0);
    op(1'b0, 32'h0000_0004, 32'h0, 7, K_DONE_R, "R4 delayed ack", 1'b0);
    // top of the port range, upper host bits set
    op(1'b1, 32'h1234_5FFC, 32'hDEAD_BEEF, 2, K_DONE_W, "R2 top address", 1'b0);
    op(1'b0, 32'h0000_0FFC, 32'h0, 1, K_DONE_R, "R4 top address", 1'b0);
    op(1'b0, 32'h0000_0200, 32'h0, 0, K_DONE_R, "R4 unwritten word", 1'b0);

    // R6: misaligned requests raise no strobe
    s0 = stb_cycles;
    op(1'b1, 32'h0000_0101, 32'h5555_AAAA, 0, K_ALIGN, "R6 offset 1", 1'b0);
    op(1'b0, 32'h0000_0102, 32'h0, 0, K_ALIGN, "R6 offset 2", 1'b0);
    op(1'b1, 32'h0000_0003, 32'h0, 0, K_ALIGN, "R6 offset 3", 1'b0);
    check(stb_cycles == s0, "R6 no strobe on misaligned", 32'(stb_cycles), 32'(s0));

    // R7: timeout boundaries
    op(1'b1, 32'h0000_0040, 32'h0BAD_F00D, 64, K_TMO, "R7 write timeout", 1'b0);
    op(1'b0, 32'h0000_0040, 32'h0, 64, K_TMO, "R7 read timeout", 1'b0);
    op(1'b1, 32'h0000_0044, 32'hCAFE_0001, 63, K_DONE_W, "R7 write last-cycle ack", 1'b0);
    op(1'b0, 32'h0000_0044, 32'h0, 63, K_DONE_R, "R7 read last-cycle ack", 1'b0);

    // R8: request while busy is ignored
    op(1'b1, 32'h0000_0080, 32'h0102_0304, 10, K_DONE_W, "R8 write with intrusion", 1'b0 | 1'b1);
    op(1'b0, 32'h0000_0080, 32'h0, 10, K_DONE_R, "R8 read with intrusion", 1'b1);

    // R9: acknowledge while idle does nothing
    s0 = stb_cycles;
    @(negedge clk);
    force_ack = 1'b1;
    @(negedge clk);
    force_ack = 1'b0;
    repeat (4) @(negedge clk);
    check(!host_busy && !host_done && stb_cycles == s0, "R9 idle ack ignored",
          {31'h0, host_busy}, 32'h0);

    // R10: a write after a read keeps the read word
    op(1'b0, 32'h0000_0100, 32'h0, 0, K_DONE_R, "R10 read", 1'b0);
    op(1'b1, 32'h0000_0108, 32'h7777_8888, 0, K_DONE_W, "R10 write", 1'b0);

    // Mixed patterns
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      logic [31:0] d;
      a = 32'((i * 52 + 16) & 12'hFFC);
      d = 32'h9E37_79B9 * 32'(i + 1) ^ 32'(i << 8);
      op(1'b1, a, d, i % 3, K_DONE_W, "R2 pattern write", 1'b0);
      op(1'b0, a, 32'h0, (i * 5) % 9, K_DONE_R, "R4 pattern read", 1'b0);
    end

    check(ovl_cnt == 0, "R5 strobe overlap or idle strobe", 32'(ovl_cnt), 32'h0);
    check(sb_q.size() == 0, "R3 scoreboard drained", 32'(sb_q.size()), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule